// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Unit

This block holds the replacement history of an 8-way set-associative cache with 128 sets. Each set carries a 7-bit binary tree. Every node of the tree points toward the half of the set that should be replaced next. When the cache hits or fills a line, it reports that way through the touch port. The unit then rewrites the nodes on that way's path so that they point away from it. Each way has a fixed clear pattern and a fixed set pattern for this rewrite.

The victim query is purely combinational. The cache presents a set index and that set's 8-bit line-valid mask, and receives the way to fill. The lowest-numbered empty way wins whenever one exists. When the set is full, the tree chooses the victim.

A synchronous clear input empties the whole history in one cycle, as the asynchronous reset does. The reset is released through an internal two-stage synchronizer.

Top module: `plru_repl_unit`

## Requirements
- R1: After reset is released, every set's tree is all zeros, so a query with a full valid mask returns way 0 for every set.
- R2: A touch of way w rewrites the addressed set's tree as (tree AND NOT clr[w]) OR set[w]. The clear patterns for ways 0..7 are 11, 11, 19, 19, 37, 37, 69, 69 and the set patterns are 11, 3, 17, 1, 36, 4, 64, 0 (decimal, bit 0 is the root). The new tree is visible from the cycle after the touch edge.
- R3: When the valid mask (bit i for way i) has at least one zero bit, the victim is the index of the lowest zero bit, whatever the tree holds.
- R4: With a valid mask of all ones, the victim comes from the tree. Root bit 0 picks ways 4..7 when 1 and ways 0..3 when 0. Bit 1 picks ways 2/3 over 0/1, and bit 2 picks ways 6/7 over 4/5. Leaf bits 3, 4, 5 and 6 (pairs 0/1, 2/3, 4/5, 6/7) pick the odd way when 1.
- R5: A touch changes only the tree of the set it addresses.
- R6: A query to the set being touched in the same cycle answers from the tree as it was before that touch.
- R7: A clear zeroes every set's tree at the next edge and takes priority over a touch presented in the same cycle.
- R8: With a full valid mask, the victim of a set is never the way that was most recently touched in that set.
- R9: With the touch valid low, the presented set and way have no effect on any tree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of all trees |
| touch_vld_i | input | 1 | Touch request valid |
| touch_set_i | input | 7 | Set index of the touch |
| touch_way_i | input | 3 | Way hit or filled |
| query_set_i | input | 7 | Set index of the victim query |
| query_valid_i | input | 8 | Line-valid mask of the queried set, bit i for way i |
| victim_way_o | output | 3 | Way to replace |

## Verification
A corrupted tree appears at the ports only when the victim query addresses that set with a full valid mask. A partial mask masks the fault completely. A wrong node therefore shows up as a wrong victim in the first full-mask query after the faulty touch, which can be one cycle later. A node off the selected path stays hidden until later touches steer the decode through it. For this reason the bench mirrors every set's tree and queries full sets after each touch in several orders. It also queries untouched neighbour sets, the same-cycle touch and query, and the cycle after a clear.

// File: rtl/plru_pkg.sv
package plru_pkg;
  localparam int WAYS   = 8;
  localparam int WAY_W  = 3;
  localparam int TREE_W = WAYS - 1;

  // Nodes on the path of a way: root, half node, leaf of its pair.
  function automatic logic [TREE_W-1:0] path_bits(input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] m;
    m = '0;
    m[0] = 1'b1;
    m[w[2] ? 2 : 1] = 1'b1;
    m[3 + w[2:1]] = 1'b1;
    return m;
  endfunction

  // Each node on the path is forced to point away from the touched way.
  function automatic logic [TREE_W-1:0] point_away(input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] v;
    v = '0;
    v[0] = ~w[2];
    v[w[2] ? 2 : 1] = ~w[1];
    v[3 + w[2:1]] = ~w[0];
    return v;
  endfunction
endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [TREE_W-1:0] wr_tree_i,
  input  logic [SET_W-1:0]  rd_a_set_i,
  output logic [TREE_W-1:0] rd_a_tree_o,
  input  logic [SET_W-1:0]  rd_b_set_i,
  output logic [TREE_W-1:0] rd_b_tree_o
);
  logic [TREE_W-1:0] tree_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic              hit;
    logic              en;
    logic [TREE_W-1:0] d;

    always_comb begin
      hit = wr_en_i && (wr_set_i == SET_W'(s));
      en  = clr_i || hit;
      d   = clr_i ? '0 : wr_tree_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tree_q[s] <= '0;
      else if (en) tree_q[s] <= d;
    end
  end

  assign rd_a_tree_o = tree_q[rd_a_set_i];
  assign rd_b_tree_o = tree_q[rd_b_set_i];
endmodule

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_pkg::*;
(
  input  logic [TREE_W-1:0] tree_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [TREE_W-1:0] tree_o
);
  always_comb begin
    tree_o = (tree_i & ~path_bits(way_i)) | point_away(way_i);
  end
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
  import plru_pkg::*;
(
  input  logic [TREE_W-1:0] tree_i,
  input  logic [WAYS-1:0]   valid_i,
  output logic [WAY_W-1:0]  way_o
);
  logic [WAY_W-1:0] empty_way;
  logic             any_empty;
  logic [WAY_W-1:0] tree_way;

  // Lowest-numbered empty way, scanned from the top so the lowest wins.
  always_comb begin
    empty_way = '0;
    any_empty = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        empty_way = WAY_W'(i);
        any_empty = 1'b1;
      end
    end
  end

  always_comb begin
    tree_way[2] = tree_i[0];
    tree_way[1] = tree_i[0] ? tree_i[2] : tree_i[1];
    tree_way[0] = tree_i[3 + {tree_way[2], tree_way[1]}];
  end

  assign way_o = any_empty ? empty_way : tree_way;
endmodule

// File: rtl/plru_repl_unit.sv
module plru_repl_unit
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             touch_vld_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] query_set_i,
  input  logic [WAYS-1:0]  query_valid_i,
  output logic [WAY_W-1:0] victim_way_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [TREE_W-1:0] touch_tree_cur;
  logic [TREE_W-1:0] touch_tree_nxt;
  logic [TREE_W-1:0] query_tree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  plru_tree_store #(.NUM_SETS(NUM_SETS)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr_i       (clr_i),
    .wr_en_i     (touch_vld_i),
    .wr_set_i    (touch_set_i),
    .wr_tree_i   (touch_tree_nxt),
    .rd_a_set_i  (touch_set_i),
    .rd_a_tree_o (touch_tree_cur),
    .rd_b_set_i  (query_set_i),
    .rd_b_tree_o (query_tree)
  );

  plru_tree_update u_update (
    .tree_i (touch_tree_cur),
    .way_i  (touch_way_i),
    .tree_o (touch_tree_nxt)
  );

  plru_victim_pick u_pick (
    .tree_i  (query_tree),
    .valid_i (query_valid_i),
    .way_o   (victim_way_o)
  );
endmodule

// File: rtl/plru_repl_checker.sv
module plru_repl_checker #(
  parameter int SET_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             touch_vld_i,
  input logic [SET_W-1:0] touch_set_i,
  input logic [2:0]       touch_way_i,
  input logic [SET_W-1:0] query_set_i,
  input logic [7:0]       query_valid_i,
  input logic [2:0]       victim_way_o
);
  logic [7:0] below_mask;
  always_comb below_mask = (8'd1 << victim_way_o) - 8'd1;

  // R3: victim is an empty way and every way below it is occupied
  a_r3_lowest_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (query_valid_i != 8'hFF) |->
      (!query_valid_i[victim_way_o] && ((query_valid_i & below_mask) == below_mask)));

  // R8: the way just touched is not chosen for that full set
  a_r8_not_recent: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_vld_i && !clr_i) |=>
      (query_valid_i != 8'hFF || query_set_i != $past(touch_set_i) ||
       victim_way_o != $past(touch_way_i)));

  // R7: after a clear a full set yields way 0
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (query_valid_i != 8'hFF || victim_way_o == 3'd0));

  // R9: without touch or clear, a steady query keeps a steady answer
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!touch_vld_i && !clr_i) |=>
      (!($stable(query_set_i) && $stable(query_valid_i)) || $stable(victim_way_o)));
endmodule

bind plru_repl_unit plru_repl_checker #(.SET_W(SET_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .clr_i         (clr_i),
  .touch_vld_i   (touch_vld_i),
  .touch_set_i   (touch_set_i),
  .touch_way_i   (touch_way_i),
  .query_set_i   (query_set_i),
  .query_valid_i (query_valid_i),
  .victim_way_o  (victim_way_o)
);

// File: tb/plru_repl_unit_tb.sv
module plru_repl_unit_tb;
  logic       clk;
  logic       rst_n;
  logic       clr_i;
  logic       touch_vld_i;
  logic [6:0] touch_set_i;
  logic [2:0] touch_way_i;
  logic [6:0] query_set_i;
  logic [7:0] query_valid_i;
  logic [2:0] victim_way_o;

  plru_repl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .touch_vld_i(touch_vld_i),
    .touch_set_i(touch_set_i), .touch_way_i(touch_way_i),
    .query_set_i(query_set_i), .query_valid_i(query_valid_i),
    .victim_way_o(victim_way_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { int exp; string req; } item_t;
  item_t sb_q[$];
  event  mon_ev;
  int    n_checks = 0;
  int    n_fail   = 0;
  logic [6:0] model [128];

  // Patterns from R2
  int clr_pat [8] = '{11, 11, 19, 19, 37, 37, 69, 69};
  int set_pat [8] = '{11, 3, 17, 1, 36, 4, 64, 0};

  function automatic logic [6:0] model_touch(logic [6:0] st, int w);
    return (st & ~7'(clr_pat[w])) | 7'(set_pat[w]);
  endfunction

  // R3 then R4
  function automatic int model_victim(logic [6:0] st, logic [7:0] v);
    if (v != 8'hFF) begin
      for (int i = 0; i < 8; i++) if (!v[i]) return i;
    end
    if (!st[0]) begin
      if (!st[1]) return st[3] ? 1 : 0;
      else        return st[4] ? 3 : 2;
    end else begin
      if (!st[2]) return st[5] ? 5 : 4;
      else        return st[6] ? 7 : 6;
    end
  endfunction

  // Monitor: pops expected items as results settle
  initial begin
    forever begin
      item_t it;
      @(mon_ev);
      #1;
      it = sb_q.pop_front();
      n_checks++;
      if (int'(victim_way_o) != it.exp) begin
        n_fail++;
        $display("FAIL %s: victim actual %0d expected %0d", it.req, victim_way_o, it.exp);
      end
    end
  end

  task automatic query(input int s, input logic [7:0] v, input string req);
    @(negedge clk);
    query_set_i   = 7'(s);
    query_valid_i = v;
    sb_q.push_back('{model_victim(model[s], v), req});
    -> mon_ev;
    #2;
  endtask

  task automatic touch(input int s, input int w);
    @(negedge clk);
    touch_vld_i = 1'b1;
    touch_set_i = 7'(s);
    touch_way_i = 3'(w);
    @(posedge clk);
    model[s] = model_touch(model[s], w);
    #1 touch_vld_i = 1'b0;
  endtask

  task automatic do_clear(input logic with_touch, input int s, input int w);
    @(negedge clk);
    clr_i = 1'b1;
    touch_vld_i = with_touch;
    touch_set_i = 7'(s);
    touch_way_i = 3'(w);
    @(posedge clk);
    for (int i = 0; i < 128; i++) model[i] = '0;
    #1;
    clr_i = 1'b0;
    touch_vld_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual run still going, expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; touch_vld_i = 1'b0;
    touch_set_i = '0; touch_way_i = '0; query_set_i = '0; query_valid_i = 8'hFF;
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    query(0, 8'hFF, "R1");
    query(77, 8'hFF, "R1");
    query(127, 8'hFF, "R1");

    // R3: lowest empty way regardless of tree
    touch(9, 0);
    touch(9, 5);
    query(9, 8'h00, "R3");
    query(9, 8'h01, "R3");
    query(9, 8'h7F, "R3");
    query(9, 8'hEF, "R3");
    query(9, 8'hF5, "R3");

    // R2/R4/R8: touch sequences, each followed by a full query
    begin
      int seq [12] = '{0, 7, 3, 4, 1, 6, 2, 5, 5, 0, 7, 2};
      for (int k = 0; k < 12; k++) begin
        touch(3, seq[k]);
        query(3, 8'hFF, "R2_R4");
        if (victim_way_o == 3'(seq[k])) begin
          n_fail++;
          $display("FAIL R8: victim actual %0d expected not %0d", victim_way_o, seq[k]);
        end
        n_checks++;
      end
    end

    // R5: neighbouring sets untouched
    query(2, 8'hFF, "R5");
    query(4, 8'hFF, "R5");

    // R6: same-cycle touch and query answer from the old tree
    @(negedge clk);
    touch_vld_i = 1'b1; touch_set_i = 7'd3; touch_way_i = 3'(model_victim(model[3], 8'hFF));
    query_set_i = 7'd3; query_valid_i = 8'hFF;
    sb_q.push_back('{model_victim(model[3], 8'hFF), "R6"});
    -> mon_ev;
    @(posedge clk);
    model[3] = model_touch(model[3], int'(touch_way_i));
    #1 touch_vld_i = 1'b0;
    query(3, 8'hFF, "R6");

    // R9: set and way presented with valid low
    @(negedge clk);
    touch_set_i = 7'd3; touch_way_i = 3'd1;
    repeat (2) @(posedge clk);
    query(3, 8'hFF, "R9");

    // R8: random touches on a set
    for (int k = 0; k < 200; k++) begin
      int w;
      w = int'($urandom_range(7, 0));
      touch(20, w);
      @(negedge clk);
      query_set_i = 7'd20; query_valid_i = 8'hFF;
      #1;
      n_checks++;
      if (int'(victim_way_o) == w || int'(victim_way_o) != model_victim(model[20], 8'hFF)) begin
        n_fail++;
        $display("FAIL R8: victim actual %0d expected %0d (not %0d)",
                 victim_way_o, model_victim(model[20], 8'hFF), w);
      end
    end

    // R7: clear, then clear with a simultaneous touch
    do_clear(1'b0, 0, 0);
    query(3, 8'hFF, "R7");
    query(20, 8'hFF, "R7");
    touch(40, 0);
    do_clear(1'b1, 40, 0);
    query(40, 8'hFF, "R7");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule